// File: doc/BRIEF.md
# Serial Link Break and Idle-Clock Sequencer

This block is the master side of a two-wire serial link. It drives a link clock and a data line. Commands arrive as 32-bit words on a valid/ready port. The block runs two link maintenance sequences in hardware, without software pacing each clock. When a sequence ends, it reports the result on a one-cycle status strobe.

The break command runs three fixed phases. First comes a pre-roll with the data line high, which paces and flushes the link. Next is a long stretch with the data line low. Last is a very long high recovery, so that the far end can resynchronise. The idle-clock command sends a burst of clocks with the data line high. The length of the burst comes from a byte of the command word. It can be used to flush the link, for example before a poll.

The link clock is the system clock divided by the parameter `DIV`. In each link-clock period the clock is low for the first half and high for the second half. The counted event is the rising edge. Any command word with an unknown opcode is rejected with an error status and causes no link activity.

Top module: `link_break_seq`

## Requirements
- R1: When idle, `link_clk` and `link_data` are both high, `cmd_ready` is high and `busy` is low; this is also the state right after reset.
- R2: After a command is accepted (`cmd_valid` and `cmd_ready` both high at a clock edge), `cmd_ready` is low and `busy` is high until the status strobe. `stat_valid` is high for exactly one cycle while `busy` is still high. `busy` is low in the cycle after the strobe.
- R3: While a sequence runs, each link-clock period lasts `DIV` system clocks: `DIV/2` cycles low, then `DIV/2` cycles high. `link_data` changes only in a cycle where `link_clk` is low.
- R4: A break first issues `PRE_CLKS` link-clock rising edges (default 50) with `link_data` high, before `link_data` goes low.
- R5: During a break, `link_data` stays low for exactly `LOW_CLKS` link-clock rising edges (default 256).
- R6: After the low period, a break issues `POST_CLKS` rising edges (default 16000) with `link_data` high. It then posts status code 2'b01 (complete).
- R7: An idle-clock command issues exactly N link-clock rising edges, where N is `cmd_data[15:8]` (1 to 255). `link_data` stays high throughout, and status code 2'b01 follows.
- R8: An idle-clock command with N = 0 posts status 2'b01 in the cycle after accept and issues no link-clock edge.
- R9: An opcode other than 0x01 or 0x02 posts status code 2'b10 (invalid command) in the cycle after accept. `link_clk` and `link_data` stay high.
- R10: The opcode is `cmd_data[7:0]`: 0x01 selects break and 0x02 selects idle clocks. Bits [31:16] are ignored, and so are bits [15:8] for a break.

Note: `cmd_data[15:8]` and status codes 2'b01 and 2'b10 are the only field positions and code values the block defines beyond the opcode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word is offered |
| cmd_ready | output | 1 | Block can take a command (idle) |
| cmd_data | input | 32 | Command word: [7:0] opcode, [15:8] idle-clock count |
| busy | output | 1 | High from accept until the status strobe |
| stat_valid | output | 1 | One-cycle status strobe |
| stat_code | output | 2 | 2'b01 complete, 2'b10 invalid command |
| link_clk | output | 1 | Link clock, rests high |
| link_data | output | 1 | Link data line, rests high |

## Verification
The bound checker watches these rules on every cycle:
- the idle rest levels of both link lines;
- that data moves only while the link clock is low;
- the accept-to-busy and strobe-to-idle handshake;
- the legal status codes;
- that the low stretch of a break holds exactly the configured number of rising edges.

Some behaviour can only be shown by the bench's command scenarios, which count edges per phase in a scoreboard:
- that each phase and burst has the right length;
- that the count field is taken from the right byte;
- that a zero count and a bad opcode leave the link silent;
- that stray upper bits are ignored.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_LOW   = 3'd2,
    ST_POST  = 3'd3,
    ST_BURST = 3'd4,
    ST_DONE  = 3'd5
  } lbs_state_e;

  localparam logic [7:0] OP_BREAK = 8'h01;
  localparam logic [7:0] OP_IDLE  = 8'h02;

  localparam logic [1:0] STAT_OK     = 2'b01;
  localparam logic [1:0] STAT_BADCMD = 2'b10;
endpackage

// File: rtl/lbs_clkgen.sv
module lbs_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic link_clk,
  output logic period_end
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = run || (cnt_q != '0);
    if (!run)                        cnt_d = '0;
    else if (cnt_q == CW'(DIV - 1))  cnt_d = '0;
    else                             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign link_clk   = !run || (cnt_q >= CW'(HALF));
  assign period_end = run && (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/lbs_phase_ctr.sv
module lbs_phase_ctr #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || dec;
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/lbs_ctrl.sv
module lbs_ctrl
  import lbs_pkg::*;
#(
  parameter int W         = 14,
  parameter int PRE_CLKS  = 50,
  parameter int LOW_CLKS  = 256,
  parameter int POST_CLKS = 16000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [31:0]  cmd_data,
  input  logic         period_end,
  input  logic         last,
  output logic         cmd_ready,
  output logic         busy,
  output logic         run,
  output logic         load,
  output logic [W-1:0] load_val,
  output logic         dec,
  output logic         stat_valid,
  output logic [1:0]   stat_code,
  output logic         link_data
);
  lbs_state_e state_q, state_d;
  logic [1:0] code_q, code_d;
  logic       code_en;
  logic       accept;
  logic [7:0] opcode;
  logic [7:0] burst_n;

  assign accept  = cmd_valid && (state_q == ST_IDLE);
  assign opcode  = cmd_data[7:0];
  assign burst_n = cmd_data[15:8];

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    code_en  = 1'b0;
    load     = 1'b0;
    load_val = '0;
    dec      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          code_en = 1'b1;
          code_d  = STAT_OK;
          if (opcode == OP_BREAK) begin
            load     = 1'b1;
            load_val = W'(PRE_CLKS);
            state_d  = ST_PRE;
          end else if (opcode == OP_IDLE) begin
            if (burst_n != 8'd0) begin
              load     = 1'b1;
              load_val = W'(burst_n);
              state_d  = ST_BURST;
            end else begin
              state_d  = ST_DONE;
            end
          end else begin
            code_d  = STAT_BADCMD;
            state_d = ST_DONE;
          end
        end
      end
      ST_PRE: if (period_end) begin
        if (last) begin
          load     = 1'b1;
          load_val = W'(LOW_CLKS);
          state_d  = ST_LOW;
        end else dec = 1'b1;
      end
      ST_LOW: if (period_end) begin
        if (last) begin
          load     = 1'b1;
          load_val = W'(POST_CLKS);
          state_d  = ST_POST;
        end else dec = 1'b1;
      end
      ST_POST, ST_BURST: if (period_end) begin
        if (last) state_d = ST_DONE;
        else      dec     = 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= STAT_OK;
    else if (code_en) code_q <= code_d;
  end

  assign cmd_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign run        = (state_q == ST_PRE) || (state_q == ST_LOW) ||
                      (state_q == ST_POST) || (state_q == ST_BURST);
  assign stat_valid = (state_q == ST_DONE);
  assign stat_code  = code_q;
  assign link_data  = (state_q != ST_LOW);
endmodule

// File: rtl/link_break_seq.sv
module link_break_seq #(
  parameter int DIV       = 4,
  parameter int PRE_CLKS  = 50,
  parameter int LOW_CLKS  = 256,
  parameter int POST_CLKS = 16000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [31:0] cmd_data,
  output logic        busy,
  output logic        stat_valid,
  output logic [1:0]  stat_code,
  output logic        link_clk,
  output logic        link_data
);
  localparam int MAX_A = (PRE_CLKS > LOW_CLKS) ? PRE_CLKS : LOW_CLKS;
  localparam int MAX_B = (POST_CLKS > 255) ? POST_CLKS : 255;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int W     = $clog2(MAXC + 1);

  logic         run, period_end, last, load, dec;
  logic [W-1:0] load_val;

  lbs_clkgen #(.DIV(DIV)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .link_clk   (link_clk),
    .period_end (period_end)
  );

  lbs_phase_ctr #(.W(W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .dec      (dec),
    .last     (last)
  );

  lbs_ctrl #(
    .W(W), .PRE_CLKS(PRE_CLKS), .LOW_CLKS(LOW_CLKS), .POST_CLKS(POST_CLKS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_data   (cmd_data),
    .period_end (period_end),
    .last       (last),
    .cmd_ready  (cmd_ready),
    .busy       (busy),
    .run        (run),
    .load       (load),
    .load_val   (load_val),
    .dec        (dec),
    .stat_valid (stat_valid),
    .stat_code  (stat_code),
    .link_data  (link_data)
  );
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int LOW_CLKS = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       busy,
  input logic       stat_valid,
  input logic [1:0] stat_code,
  input logic       link_clk,
  input logic       link_data
);
  int unsigned low_rises;
  logic        clk_prev, data_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_rises <= 0;
      clk_prev  <= 1'b1;
      data_prev <= 1'b1;
    end else begin
      clk_prev  <= link_clk;
      data_prev <= link_data;
      if (data_prev && !link_data)                low_rises <= 0;
      else if (!clk_prev && link_clk && !link_data) low_rises <= low_rises + 1;
    end
  end

  AST_IDLE_REST: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (link_clk && link_data && cmd_ready)); // R1

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready)); // R2

  AST_STAT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> (!busy && !stat_valid)); // R2

  AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_data) |-> !link_clk); // R3

  AST_LOW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_prev && link_data) |-> (low_rises == LOW_CLKS)); // R5

  AST_STAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_code == 2'b01 || stat_code == 2'b10)); // R9
endmodule

bind link_break_seq lbs_checker #(.LOW_CLKS(LOW_CLKS)) u_lbs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .busy       (busy),
  .stat_valid (stat_valid),
  .stat_code  (stat_code),
  .link_clk   (link_clk),
  .link_data  (link_data)
);

// File: tb/link_break_seq_bench.sv
module link_break_seq_bench;
  localparam int DIV = 4;

  logic        clk, rst_n, cmd_valid;
  logic [31:0] cmd_data;
  logic        cmd_ready, busy, stat_valid, link_clk, link_data;
  logic [1:0]  stat_code;

  link_break_seq #(.DIV(DIV)) u_link_break_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .busy(busy), .stat_valid(stat_valid),
    .stat_code(stat_code), .link_clk(link_clk), .link_data(link_data)
  );

  typedef struct {
    logic [1:0] code;
    int         pre;
    int         low;
    int         post;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state
  int  n_pre, n_low, n_post, hi_cnt, lo_cnt, per_err, data_err;
  bit  seen_low, prev_clk, prev_data, first_rise;

  initial begin
    n_pre = 0; n_low = 0; n_post = 0; seen_low = 0;
    per_err = 0; data_err = 0; hi_cnt = 0; lo_cnt = 0;
    prev_clk = 1; prev_data = 1; first_rise = 1;
  end

  always @(negedge clk) if (rst_n) begin
    if (link_data != prev_data && link_clk) data_err++;
    if (link_clk) hi_cnt++; else lo_cnt++;
    if (!prev_clk && link_clk) begin
      if (lo_cnt != DIV/2) per_err++;
      lo_cnt = 0;
      if (!link_data) begin n_low++; seen_low = 1; end
      else if (seen_low) n_post++;
      else n_pre++;
    end
    if (prev_clk && !link_clk) begin
      if (busy && !first_rise && hi_cnt != DIV/2) per_err++;
      first_rise = 0;
      hi_cnt = 0;
    end
    if (!busy) begin hi_cnt = 0; lo_cnt = 0; first_rise = 1; end
    prev_clk  = link_clk;
    prev_data = link_data;
    if (stat_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected status", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(busy == 1'b1, {e.tag, " busy at status"}, busy, 1);
        check(stat_code == e.code, {e.tag, " status code"}, stat_code, e.code);
        check(n_pre == e.pre, {e.tag, " high clocks before low"}, n_pre, e.pre);
        check(n_low == e.low, {e.tag, " low clocks"}, n_low, e.low);
        check(n_post == e.post, {e.tag, " high clocks after low"}, n_post, e.post);
      end
      n_pre = 0; n_low = 0; n_post = 0; seen_low = 0;
    end
  end

  task automatic send(input logic [31:0] word, input logic [1:0] code,
                      input int pre, input int low, input int post, input string tag);
    exp_t e;
    e.code = code; e.pre = pre; e.low = low; e.post = post; e.tag = tag;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    exp_q.push_back(e);
    cmd_valid = 1'b1;
    cmd_data  = word;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = 32'h0;
    check(busy == 1'b1 && cmd_ready == 1'b0, "R2 busy after accept", busy, 1);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(!busy && cmd_ready && link_clk && link_data, "R1 idle after status",
          {busy, cmd_ready, link_clk, link_data}, 4'b0111);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = 32'h0;
    repeat (3) @(negedge clk);
    check(!busy && cmd_ready && link_clk && link_data && !stat_valid,
          "R1 reset state", {busy, cmd_ready, link_clk, link_data}, 4'b0111);
    rst_n = 1'b1;
    send(32'h0000_0502, 2'b01, 5, 0, 0, "R7 burst of 5");
    send(32'h0000_0002, 2'b01, 0, 0, 0, "R8 zero burst");
    send(32'h0000_0007, 2'b10, 0, 0, 0, "R9 bad opcode 0x07");
    send(32'h0000_0100, 2'b10, 0, 0, 0, "R9 bad opcode 0x00");
    send(32'h0000_FF02, 2'b01, 255, 0, 0, "R7 burst of 255");
    send(32'hABCD_0302, 2'b01, 3, 0, 0, "R10 upper bits ignored");
    send(32'hFFFF_7701, 2'b01, 50, 256, 16000, "R4 R5 R6 break");
    check(per_err == 0, "R3 link clock period", per_err, 0);
    check(data_err == 0, "R3 data moved while clock high", data_err, 0);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(0, "watchdog expired", cyc, 200000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule